// File: doc/BRIEF.md
# Restartable Pulse Oscillator Voice

This block is one voice of a tone generator, cut down to its pulse waveform. A 24-bit phase accumulator adds a 16-bit step value on every clock. The top 12 accumulator bits are compared against a 12-bit duty threshold. The single-bit output is high while those bits are below the threshold, and low once they reach or pass it.

A hold bit in the control register clears the accumulator and keeps it at zero for as long as the bit stays set. Software can therefore restart the oscillator at a known instant. After the bit is cleared, the output stays high for a number of cycles equal to the threshold divided by the per-cycle advance of the compared bits. The voice then acts as a one-shot PWM timer driven by register writes. If the hold is released for a fixed time each period, that time only adds a constant offset to the high time.

All registers are loaded through one byte-wide write port. A write takes effect on the clock edge at which the strobe is sampled.

Top module: `pulse_voice`

## Requirements
- R1: After reset the accumulator, step value, threshold and hold bit are all zero, and `pulseOut` is low.
- R2: Byte writes use this address map: 0 is the step low byte, 1 is the step high byte, 2 is the threshold low byte, 3 holds the threshold upper nibble in data bits 3:0, and 4 is the control register. A write to addresses 5, 6 or 7 changes nothing that can be observed.
- R3: While the hold bit (control bit 0) is set, `pulseOut` is high whatever the threshold, including a threshold of zero. It is high from the edge at which the set is written.
- R4: While the hold bit is set, the accumulator stays at zero. The accumulator adds the step on each edge, starting at the edge after the one that clears the bit. As a result, with step S and threshold P, `pulseOut` falls after the smallest number j of edges for which bits 23:12 of j*S are at least P. With S = 0x4000 this is ceil(P/4).
- R5: The threshold is the 12-bit value {high nibble, low byte}. For example, a threshold of 0x100 with step 0x4000 gives 64 high cycles.
- R6: A threshold of zero gives a low output from the moment counting resumes.
- R7: A threshold write during a run changes the comparison from the edge of the write onward.
- R8: The accumulator wraps modulo 2^24, so the output rises again when the count wraps. With step 0x4000 it rises 1024 edges after release.
- R9: Only bit 0 of the control register has an effect. Writing 0xFE neither sets the hold nor disturbs a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Write data byte |
| pulseOut | output | 1 | Pulse waveform output |

## Verification
The hardest condition to reach from the ports is the wrap of the accumulator back through zero while the hold bit is clear. This is the only way the output can rise without a restart. To reach it, the bench releases the hold with a 0x4000 step and lets the count run past the fall, then counts edges until the output rises at the 1024th edge. Changing the threshold during a run is also a narrow target. The bench places that write at a known edge after release and checks that the fall moves to the new point.

// File: rtl/pulse_voice_pkg.sv
package pulse_voice_pkg;
  parameter int ACC_W   = 24;
  parameter int FREQ_W  = 16;
  parameter int PW_W    = 12;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 3;

  localparam int FREQ_BYTES = FREQ_W / DATA_W;
  localparam int PW_HI_W    = PW_W - DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_FREQ0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PW_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PW_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 3'd4;

  typedef struct packed {
    logic [FREQ_BYTES-1:0] freqByteWe;
    logic                  pwLoWe;
    logic                  pwHiWe;
    logic                  accHold;
    logic                  forceHigh;
    logic [DATA_W-1:0]     wdata;
  } voiceStrobes_t;
endpackage

// File: rtl/pwv_control.sv
module pwv_control
  import pulse_voice_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output voiceStrobes_t     strb,
  output logic              testBit
);
  logic ctlWe;
  logic [FREQ_BYTES-1:0] freqWe;

  genvar gi;
  generate
    for (gi = 0; gi < FREQ_BYTES; gi++) begin : g_freqDec
      localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_FREQ0 + ADDR_W'(gi);
      assign freqWe[gi] = wrEn && (wrAddr == BYTE_ADDR);
    end
  endgenerate

  assign ctlWe = wrEn && (wrAddr == ADDR_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) testBit <= 1'b0;
    else if (ctlWe) testBit <= wrData[0];
  end

  always_comb begin
    strb.freqByteWe = freqWe;
    strb.pwLoWe     = wrEn && (wrAddr == ADDR_PW_LO);
    strb.pwHiWe     = wrEn && (wrAddr == ADDR_PW_HI);
    strb.accHold    = testBit;
    strb.forceHigh  = testBit;
    strb.wdata      = wrData;
  end
endmodule

// File: rtl/pwv_datapath.sv
module pwv_datapath
  import pulse_voice_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  voiceStrobes_t     strb,
  output logic              pulseOut,
  output logic [ACC_W-1:0]  accVal,
  output logic [PW_W-1:0]   pwVal,
  output logic [FREQ_W-1:0] freqVal
);
  logic [DATA_W-1:0]  pwLo;
  logic [PW_HI_W-1:0] pwHi;
  logic [PW_W-1:0]    phaseTop;
  logic               belowWidth;

  genvar gi;
  generate
    for (gi = 0; gi < FREQ_BYTES; gi++) begin : g_freqReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) freqVal[gi*DATA_W +: DATA_W] <= '0;
        else if (strb.freqByteWe[gi]) freqVal[gi*DATA_W +: DATA_W] <= strb.wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwLo <= '0;
      pwHi <= '0;
    end else begin
      if (strb.pwLoWe) pwLo <= strb.wdata;
      if (strb.pwHiWe) pwHi <= strb.wdata[PW_HI_W-1:0];
    end
  end

  assign pwVal = {pwHi, pwLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accVal <= '0;
    else if (strb.accHold) accVal <= '0;
    else accVal <= accVal + ACC_W'(freqVal);
  end

  assign phaseTop   = accVal[ACC_W-1 -: PW_W];
  assign belowWidth = phaseTop < pwVal;
  assign pulseOut   = strb.forceHigh | belowWidth;
endmodule

// File: rtl/pulse_voice.sv
module pulse_voice
  import pulse_voice_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pulseOut
);
  voiceStrobes_t     strb;
  logic              testBit;
  logic [ACC_W-1:0]  accVal;
  logic [PW_W-1:0]   pwVal;
  logic [FREQ_W-1:0] freqVal;

  pwv_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .testBit(testBit)
  );

  pwv_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pulseOut(pulseOut),
    .accVal(accVal), .pwVal(pwVal), .freqVal(freqVal)
  );
endmodule

// File: rtl/pulse_voice_chk.sv
module pulse_voice_chk
  import pulse_voice_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              pulseOut,
  input logic              testBit,
  input logic [ACC_W-1:0]  accVal,
  input logic [PW_W-1:0]   pwVal,
  input logic [FREQ_W-1:0] freqVal
);
  assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTL && wrData[0]) |=> pulseOut);

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(testBit) |-> (accVal == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(testBit)) |-> (accVal == $past(accVal) + ACC_W'($past(freqVal))));

  assert_zero_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!testBit && pwVal == '0) |-> !pulseOut);

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_CTL) |=> ($stable(freqVal) && $stable(pwVal) && $stable(testBit)));

  assert_rise_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!testBit && !$past(testBit) && $stable(pwVal) && $rose(pulseOut)) |-> (accVal < $past(accVal)));
endmodule

bind pulse_voice pulse_voice_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .pulseOut(pulseOut), .testBit(testBit), .accVal(accVal), .pwVal(pwVal),
  .freqVal(freqVal)
);

// File: tb/sim_pulse_voice.sv
`timescale 1ns/1ps
module sim_pulse_voice;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pulseOut;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pulse_voice u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                  .wrData(wrData), .pulseOut(pulseOut));

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Drive on a falling edge; returns on the next falling edge after the write edge.
  task automatic writeReg(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(int freq, int pw);
    writeReg(3'd0, 8'(freq));
    writeReg(3'd1, 8'(freq >> 8));
    writeReg(3'd2, 8'(pw));
    writeReg(3'd3, 8'(pw >> 8));
  endtask

  // Hold set, then cleared; at return j = 0 (no count edge yet).
  task automatic restart();
    writeReg(3'd4, 8'h01);
    writeReg(3'd4, 8'h00);
  endtask

  task automatic waitLevel(logic lvl, int startJ, output int j);
    j = startJ;
    while (pulseOut != lvl && j < 3000) begin
      @(posedge clk); @(negedge clk);
      j++;
    end
  endtask

  task automatic testReset();
    chk("R1 reset output", int'(pulseOut), 0);
    repeat (5) @(negedge clk);
    chk("R1 idle output", int'(pulseOut), 0);
  endtask

  task automatic testHoldHigh();
    writeReg(3'd4, 8'h01);
    chk("R3 hold forces high with width 0", int'(pulseOut), 1);
    setup(16'h4000, 0);
    repeat (10) @(negedge clk);
    chk("R3 hold stays high", int'(pulseOut), 1);
    writeReg(3'd4, 8'h00);
    chk("R6 zero width low at release", int'(pulseOut), 0);
  endtask

  task automatic testFallTimes();
    int widths[5] = '{1, 4, 5, 128, 255};
    foreach (widths[k]) begin
      int j;
      setup(16'h4000, widths[k]);
      writeReg(3'd4, 8'h01);
      repeat (k * 3) @(negedge clk);
      writeReg(3'd4, 8'h00);
      chk("R4 high right after release", int'(pulseOut), 1);
      waitLevel(1'b0, 0, j);
      chk("R4 fall edges step 0x4000", j, (widths[k] + 3) / 4);
    end
  endtask

  task automatic testHighNibble();
    int j;
    setup(16'h4000, 12'h100);
    restart();
    waitLevel(1'b0, 0, j);
    chk("R5 width 0x100", j, 64);
    setup(16'h4000, 12'h3FF);
    restart();
    waitLevel(1'b0, 0, j);
    chk("R5 width 0x3FF", j, 256);
  endtask

  task automatic testOtherStep();
    int j;
    setup(16'h1000, 12'h020);
    restart();
    waitLevel(1'b0, 0, j);
    chk("R4 fall edges step 0x1000", j, 32);
  endtask

  task automatic testMidRun();
    int j;
    setup(16'h4000, 12'h040);
    restart();
    repeat (4) @(negedge clk);
    writeReg(3'd2, 8'h80);
    chk("R7 still high after widening", int'(pulseOut), 1);
    waitLevel(1'b0, 5, j);
    chk("R7 fall moved to new width", j, 32);
  endtask

  task automatic testIgnored();
    int j;
    setup(16'h4000, 12'h040);
    restart();
    writeReg(3'd5, 8'hFF);
    writeReg(3'd6, 8'h00);
    writeReg(3'd7, 8'h01);
    waitLevel(1'b0, 3, j);
    chk("R2 unmapped writes leave timing", j, 16);
    writeReg(3'd4, 8'hFE);
    chk("R9 control 0xFE does not hold", int'(pulseOut), 0);
    writeReg(3'd4, 8'hFF);
    chk("R9 control bit0 sets hold", int'(pulseOut), 1);
  endtask

  task automatic testWrap();
    int j;
    int r;
    setup(16'h4000, 12'h040);
    restart();
    waitLevel(1'b0, 0, j);
    chk("R8 initial fall", j, 16);
    writeReg(3'd4, 8'hFE);
    waitLevel(1'b1, j + 1, r);
    chk("R8 rise on wrap", r, 1024);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHoldHigh();
    testFallTimes();
    testHighNibble();
    testOtherStep();
    testMidRun();
    testIgnored();
    testWrap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule